// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Core

This block is a cycle-based model of a small dynamic memory core: 64 one-bit cells in an 8 by 8 grid. A controller sends the six-bit cell address in two halves over one three-pin address bus. It sends the row half with a row strobe and the column half with a column strobe. All strobes are active-low and are sampled on the rising clock edge.

Opening a row copies all of its cells into a bank of eight sense latches and wipes the array row. This models a destructive read. Reads pick one latch bit through a column mux. Writes load one latch bit through a column demux. When the row strobe is released, the whole latch bank is written back to the array row. The bit lines then stay in precharge for a fixed number of cycles, and the flag `precharged` shows when a new row may open.

Top module: `dram_core`

## Requirements
- R1: A synchronous reset clears all 64 cells, `dout`, `dout_vld` and `cas_err`, and sets `precharged` to 1.
- R2: A row opens on the first rising edge where `precharged` is 1 and `ras_n` is 0. The row address is taken from `addr_pins` at that edge. The column address is taken from `addr_pins` at the first edge where `cas_n` is sampled 0 after being sampled 1, while the row is open and `ras_n` is 0.
- R3: For a read (`we_n` = 1 at the column edge k), `dout` equals the addressed cell. `dout_vld` is 0 after edges k through k+RD_LAT and 1 after edge k+1+RD_LAT. It stays 1 while both strobes remain 0.
- R4: Whenever `dout_vld` is 0, `dout` is 0. `dout_vld` falls after the first edge that samples `cas_n` or `ras_n` high.
- R5: A write (`we_n` = 0 at the column edge) stores `din` into the addressed cell only. The other seven cells of that row keep their values.
- R6: A row's contents survive being opened and read, because the latch bank is written back when `ras_n` is released.
- R7: While one row stays open, several column strobe pulses can access different columns of that row.
- R8: After the edge that samples `ras_n` high on an open row, `precharged` is 0 for PRE_CYCLES edges. It is back to 1 after the (PRE_CYCLES+1)-th edge. A low `ras_n` during that time opens nothing, and the row address is taken at the first edge where `precharged` is 1.
- R9: A falling column strobe while `ras_n` is 1 is ignored: no read, no write and no valid output. It also sets `cas_err`, which stays 1 until reset.
- R10: A bit written into the open row can be read back during the same row activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_pins | input | 3 | Shared address pins: row half, then column half |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write select at the column edge, active low |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data valid |
| cas_err | output | 1 | Sticky flag: column strobe without row strobe |
| precharged | output | 1 | Bit lines precharged, so a row may open |

## Verification
The bench reads neighbours of every written cell. A demux that loaded more than one latch, or a write-back that went to the wrong row, would show up as corrupted bits there. It reads a row again after it has been read once. A core that skipped the write-back would return zeros from the wiped array. The bench also holds the row strobe low during precharge and changes the address just as precharge ends. A core that opened the row early would return data from the wrong row. Finally, it pulses the column strobe with the row strobe high. A core that acted on that pulse would drive a valid output or fail to raise the sticky error flag.

// File: rtl/dram_core_pkg.sv
package dram_core_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_PRE  = 2'd2
   } core_st_t;
endpackage

// File: rtl/dram_row_dec.sv
module dram_row_dec #(
   parameter int ROW_BITS = 3,
   localparam int ROWS = 1 << ROW_BITS
) (
   input  logic [ROW_BITS-1:0] row_addr,
   output logic [ROWS-1:0]     word_line
);
   for (genvar r = 0; r < ROWS; r++) begin : g_wl
      assign word_line[r] = (row_addr == ROW_BITS'(r));
   end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ROWS-1:0] word_line,
   input  logic            activate,
   input  logic            restore,
   input  logic [COLS-1:0] restore_row,
   output logic [COLS-1:0] sense_row
);
   logic [COLS-1:0] cells_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (rst)
            cells_q[r] <= '0;
         else if (activate && word_line[r])
            cells_q[r] <= '0;           // destructive sensing wipes the row
         else if (restore && word_line[r])
            cells_q[r] <= restore_row;
      end
   end

   always_comb begin
      sense_row = '0;
      for (int r = 0; r < ROWS; r++)
         if (word_line[r]) sense_row = sense_row | cells_q[r];
   end
endmodule

// File: rtl/dram_sense_bank.sv
module dram_sense_bank #(
   parameter int COL_BITS = 3,
   localparam int COLS = 1 << COL_BITS
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [COLS-1:0]     load_row,
   input  logic                bit_wr,
   input  logic [COL_BITS-1:0] wr_col,
   input  logic                wr_bit,
   input  logic [COL_BITS-1:0] rd_col,
   output logic [COLS-1:0]     latch_row,
   output logic                rd_bit
);
   for (genvar c = 0; c < COLS; c++) begin : g_amp
      always_ff @(posedge clk) begin
         if (rst)
            latch_row[c] <= 1'b0;
         else if (load)
            latch_row[c] <= load_row[c];
         else if (bit_wr && (wr_col == COL_BITS'(c)))
            latch_row[c] <= wr_bit;
      end
   end

   assign rd_bit = latch_row[rd_col];
endmodule

// File: rtl/dram_core.sv
module dram_core
   import dram_core_pkg::*;
#(
   parameter int ROW_BITS   = 3,
   parameter int COL_BITS   = 3,
   parameter int RD_LAT     = 1,
   parameter int PRE_CYCLES = 2,
   localparam int ADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_pins,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              din,
   output logic              dout,
   output logic              dout_vld,
   output logic              cas_err,
   output logic              precharged
);
   localparam int ROWS  = 1 << ROW_BITS;
   localparam int COLS  = 1 << COL_BITS;
   localparam int PRE_W = (PRE_CYCLES > 1) ? $clog2(PRE_CYCLES) : 1;
   localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(PRE_CYCLES - 1);

   if (ROW_BITS < 1 || ROW_BITS > 8) begin : g_bad_row
      $error("dram_core: ROW_BITS out of range");
   end
   if (COL_BITS < 1 || COL_BITS > 8) begin : g_bad_col
      $error("dram_core: COL_BITS out of range");
   end
   if (PRE_CYCLES < 1) begin : g_bad_pre
      $error("dram_core: PRE_CYCLES must be at least 1");
   end
   if (RD_LAT < 0) begin : g_bad_lat
      $error("dram_core: RD_LAT must not be negative");
   end

   core_st_t            state_q;
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic [PRE_W-1:0]    pre_cnt_q;
   logic                cas_seen_q;
   logic                read_act_q;
   logic                lat_ok;

   logic ras_on, cas_on, cas_fall;
   logic open_now, close_now, col_hit, err_hit, vld_nxt;
   logic row_open;
   logic [ROW_BITS-1:0] dec_in;
   logic [ROWS-1:0]     word_line;
   logic [COLS-1:0]     sense_row, latch_row;
   logic                sa_bit;

   assign ras_on    = !ras_n;
   assign cas_on    = !cas_n;
   assign cas_fall  = cas_on && !cas_seen_q;
   assign row_open  = (state_q == ST_OPEN);
   assign open_now  = (state_q == ST_IDLE) && ras_on;
   assign close_now = row_open && !ras_on;
   assign col_hit   = row_open && ras_on && cas_fall;
   assign err_hit   = cas_fall && !ras_on;
   assign vld_nxt   = row_open && read_act_q && ras_on && cas_on && lat_ok;
   assign dec_in    = (state_q == ST_IDLE) ? addr_pins[ROW_BITS-1:0] : row_q;
   assign precharged = (state_q == ST_IDLE);

   dram_row_dec #(.ROW_BITS(ROW_BITS)) u_dec (
      .row_addr  (dec_in),
      .word_line (word_line)
   );

   dram_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
      .clk         (clk),
      .rst         (rst),
      .word_line   (word_line),
      .activate    (open_now),
      .restore     (close_now),
      .restore_row (latch_row),
      .sense_row   (sense_row)
   );

   dram_sense_bank #(.COL_BITS(COL_BITS)) u_sense (
      .clk       (clk),
      .rst       (rst),
      .load      (open_now),
      .load_row  (sense_row),
      .bit_wr    (col_hit && !we_n),
      .wr_col    (addr_pins[COL_BITS-1:0]),
      .wr_bit    (din),
      .rd_col    (col_q),
      .latch_row (latch_row),
      .rd_bit    (sa_bit)
   );

   if (RD_LAT == 0) begin : g_nolat
      assign lat_ok = 1'b1;
   end else begin : g_lat
      localparam int LAT_W = $clog2(RD_LAT + 1);
      localparam logic [LAT_W-1:0] LAT_MAX = LAT_W'(RD_LAT);
      logic [LAT_W-1:0] lat_q;
      always_ff @(posedge clk) begin
         if (rst || col_hit)
            lat_q <= '0;
         else if (read_act_q && lat_q != LAT_MAX)
            lat_q <= lat_q + 1'b1;
      end
      assign lat_ok = (lat_q == LAT_MAX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         row_q      <= '0;
         col_q      <= '0;
         pre_cnt_q  <= '0;
         cas_seen_q <= 1'b0;
         read_act_q <= 1'b0;
         cas_err    <= 1'b0;
         dout       <= 1'b0;
         dout_vld   <= 1'b0;
      end else begin
         cas_seen_q <= cas_on;
         if (err_hit) cas_err <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (ras_on) begin
               row_q   <= addr_pins[ROW_BITS-1:0];
               state_q <= ST_OPEN;
            end
            ST_OPEN: if (!ras_on) begin
               state_q   <= ST_PRE;
               pre_cnt_q <= PRE_LOAD;
            end
            ST_PRE: begin
               if (pre_cnt_q == '0) state_q <= ST_IDLE;
               else                 pre_cnt_q <= pre_cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (col_hit) begin
            col_q      <= addr_pins[COL_BITS-1:0];
            read_act_q <= we_n;
         end else if (!cas_on || !ras_on) begin
            read_act_q <= 1'b0;
         end
         dout_vld <= vld_nxt;
         dout     <= vld_nxt & sa_bit;
      end
   end
endmodule

// File: rtl/dram_core_chk.sv
module dram_core_chk (
   input logic clk,
   input logic rst,
   input logic ras_n,
   input logic cas_n,
   input logic dout,
   input logic dout_vld,
   input logic cas_err,
   input logic precharged,
   input logic row_open
);
   AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
      !dout_vld |-> !dout); // R4
   AST_VLD_STROBES: assert property (@(posedge clk) disable iff (rst)
      dout_vld |-> ($past(!ras_n) && $past(!cas_n))); // R3
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(cas_err) |-> ($past(ras_n) && $past(!cas_n))); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      cas_err |=> cas_err); // R9
   AST_PRE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
      (row_open && ras_n) |=> (!precharged && !row_open)); // R8
   AST_OPEN_NEEDS_PRE: assert property (@(posedge clk) disable iff (rst)
      $rose(row_open) |-> ($past(precharged) && $past(!ras_n))); // R2
endmodule

bind dram_core dram_core_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .dout       (dout),
   .dout_vld   (dout_vld),
   .cas_err    (cas_err),
   .precharged (precharged),
   .row_open   (row_open)
);

// File: tb/dram_core_tb_top.sv
`timescale 1ns/1ps
module dram_core_tb_top;
   localparam int RD_LAT = 1;
   localparam int PRE_CYCLES = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] addr_pins = '0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
   logic dout, dout_vld, cas_err, precharged;
   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   dram_core #(.ROW_BITS(3), .COL_BITS(3), .RD_LAT(RD_LAT), .PRE_CYCLES(PRE_CYCLES)) dut_i (
      .clk(clk), .rst(rst), .addr_pins(addr_pins), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .din(din), .dout(dout), .dout_vld(dout_vld),
      .cas_err(cas_err), .precharged(precharged)
   );

   // vector: {is_write, row[2:0], col[2:0], data, expected}
   localparam int NVEC = 14;
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b0, 3'd0, 3'd0, 1'b0, 1'b0},
      {1'b0, 3'd7, 3'd7, 1'b0, 1'b0},
      {1'b1, 3'd2, 3'd5, 1'b1, 1'b0},
      {1'b0, 3'd2, 3'd5, 1'b0, 1'b1},
      {1'b0, 3'd2, 3'd4, 1'b0, 1'b0},
      {1'b0, 3'd2, 3'd6, 1'b0, 1'b0},
      {1'b1, 3'd5, 3'd0, 1'b1, 1'b0},
      {1'b0, 3'd5, 3'd0, 1'b0, 1'b1},
      {1'b0, 3'd2, 3'd5, 1'b0, 1'b1},
      {1'b1, 3'd2, 3'd5, 1'b0, 1'b0},
      {1'b0, 3'd2, 3'd5, 1'b0, 1'b0},
      {1'b1, 3'd7, 3'd7, 1'b1, 1'b0},
      {1'b0, 3'd7, 3'd7, 1'b0, 1'b1},
      {1'b0, 3'd6, 3'd7, 1'b0, 1'b0}
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pre(input string req);
      int n = 0;
      while (!precharged && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(req, precharged, 1);
   endtask

   // column pulse on an already open row; the strobe is released afterwards
   task automatic col_pulse(input bit wr, input logic [2:0] c, input bit d, input bit e, input string req);
      addr_pins = c; cas_n = 1'b0; we_n = !wr; din = d;
      @(negedge clk);
      we_n = 1'b1;
      if (!wr) begin
         check({req, " vld before latency"}, dout_vld, 0);
         repeat (RD_LAT) begin
            @(negedge clk);
            check({req, " vld during latency"}, dout_vld, 0);
         end
         @(negedge clk);
         check({req, " vld"}, dout_vld, 1);
         check({req, " data"}, dout, e);
      end
      cas_n = 1'b1;
      @(negedge clk);
      check("R4 vld low after cas release", dout_vld, 0);
      check("R4 dout low when not valid", dout, 0);
   endtask

   task automatic access(input bit wr, input logic [2:0] r, input logic [2:0] c,
                         input bit d, input bit e, input string req);
      addr_pins = r; ras_n = 1'b0;
      @(negedge clk);
      col_pulse(wr, c, d, e, req);
      ras_n = 1'b1;
      @(negedge clk);
      wait_pre("R8 precharge completes");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog: actual=timeout expected=finish");
      total++; bad++;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 dout", dout, 0);
      check("R1 dout_vld", dout_vld, 0);
      check("R1 cas_err", cas_err, 0);
      check("R1 precharged", precharged, 1);

      // vector walk: R3 reads, R5 writes and neighbours, R6 restore after read
      for (int i = 0; i < NVEC; i++) begin
         access(VEC[i][8], VEC[i][7:5], VEC[i][4:2], VEC[i][1], VEC[i][0],
                VEC[i][8] ? "R5 write" : "R3/R5/R6 read");
      end

      // R7 and R10: page mode on row 2
      addr_pins = 3'd2; ras_n = 1'b0;
      @(negedge clk);
      col_pulse(1'b1, 3'd1, 1'b1, 1'b0, "R7 page write");
      col_pulse(1'b0, 3'd1, 1'b0, 1'b1, "R10 read back in open row");
      col_pulse(1'b0, 3'd4, 1'b0, 1'b0, "R7 second column");
      ras_n = 1'b1;
      @(negedge clk);
      wait_pre("R8 precharge");
      access(1'b0, 3'd2, 3'd1, 1'b0, 1'b1, "R6 page write restored");

      // R8: precharge length and row strobe held during precharge
      addr_pins = 3'd3; ras_n = 1'b0;
      @(negedge clk);
      ras_n = 1'b1;
      @(negedge clk);
      check("R8 precharged low after close", precharged, 0);
      ras_n = 1'b0;                 // held low during precharge, must not open
      begin
         int n = 1;
         while (!precharged && n < 20) begin
            @(negedge clk);
            n++;
         end
         check("R8 precharge edge count", n, PRE_CYCLES + 1);
      end
      addr_pins = 3'd5;             // row 5 must be the one that opens
      @(negedge clk);
      col_pulse(1'b0, 3'd0, 1'b0, 1'b1, "R8 R2 row taken after precharge");
      ras_n = 1'b1;
      @(negedge clk);
      wait_pre("R8 precharge");

      // R9: column strobe without row strobe
      addr_pins = 3'd1; cas_n = 1'b0; we_n = 1'b0; din = 1'b1;
      @(negedge clk);
      check("R9 cas_err set", cas_err, 1);
      check("R9 no valid output", dout_vld, 0);
      @(negedge clk);
      check("R9 still no valid output", dout_vld, 0);
      cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      access(1'b0, 3'd1, 3'd1, 1'b0, 1'b0, "R9 no write took place");
      access(1'b0, 3'd2, 3'd1, 1'b0, 1'b1, "R9 stored data untouched");
      check("R9 cas_err sticky", cas_err, 1);

      // R1: reset clears cells and flags
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 cas_err cleared", cas_err, 0);
      check("R1 precharged after reset", precharged, 1);
      access(1'b0, 3'd2, 3'd1, 1'b0, 1'b0, "R1 cell cleared");
      access(1'b0, 3'd5, 3'd0, 1'b0, 1'b0, "R1 cell cleared");
      access(1'b0, 3'd7, 3'd7, 1'b0, 1'b0, "R1 cell cleared");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule